// File: doc/BRIEF.md
# Telecom Bus Clock Output Generator

This block derives the timing signals for a telecom backplane from a 16.384 MHz master clock. A free-running divider gives registered 8.192, 4.096 and 2.048 MHz clocks and an active-low frame pulse every 125 us. The same clock and frame pair drives two redundant bus outputs, A and B. Each output has its own enable, and the matching side's clock-failure flag forces that enable off.

A second output feeds line framers. A 3-bit select chooses its source: high impedance, the oscillator, the PLL clock directly, the PLL clock divided by two, or one of the four internal rates. Software writes one control byte. The select field is held pending and only takes over at the next frame boundary, so a change never cuts a clock period short.

Top module: `tbus_clkgen`

## Requirements
- R1: The internal 8.192, 4.096 and 2.048 MHz clocks come from one free-running counter that wraps every 2048 master cycles. With n master cycles since reset, each rate is high for the first half of its period, so all rates are high together when n mod 2048 is 0.
- R2: `pair_a_frm_n` and `pair_b_frm_n` are low exactly when n mod 2048 is 0 or 1, and high at every other count.
- R3: Control bit 1 picks the bus clock. A 1 gives the non-inverted 8.192 MHz clock. A 0 gives the 4.096 MHz clock inverted.
- R4: Bit 3 enables pair A and bit 2 enables pair B, each on its own. A pair's output enable is 1 only while its bit is 1 and its failure flag (`fail_a` or `fail_b`) is 0.
- R5: Both pairs carry the same clock and the same frame signal.
- R6: Select field bits 7:5: code 000 drops `fclk_oe`, 001 passes `osc_clk`, and 010 passes `pll_clk`.
- R7: Select codes 100, 101, 110 and 111 pass the internal 2.048, 4.096 and 8.192 MHz clocks and the master clock, in that order.
- R8: A new select value takes effect at the first counter wrap after the write, and not before. `fclk_oe` is 1 for every code except 000.
- R9: Bit 4 is exported on `rx_c8_mode`, and bit 0 is stored only. Neither bit changes any clock, frame or enable output, and `cfg_rdata` returns the whole written byte.
- R10: After reset the control byte reads 0x00 and all output enables are 0.
- R11: Select code 011 gives a clock that toggles on every rising edge of `pll_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| fail_a | input | 1 | A-side clock failure flag |
| fail_b | input | 1 | B-side clock failure flag |
| cfg_rdata | output | 8 | Stored control byte |
| rx_c8_mode | output | 1 | Received-clock interpretation flag |
| pair_a_clk | output | 1 | Bus clock, pair A |
| pair_a_frm_n | output | 1 | Frame pulse, pair A |
| pair_a_oe | output | 1 | Output enable, pair A |
| pair_b_clk | output | 1 | Bus clock, pair B |
| pair_b_frm_n | output | 1 | Frame pulse, pair B |
| pair_b_oe | output | 1 | Output enable, pair B |
| fclk_out | output | 1 | Framer clock |
| fclk_oe | output | 1 | Framer clock output enable |

## Verification
The assertions assume three things about the inputs. The failure flags change only away from master-clock edges. Control writes are single-cycle strobes sampled on `clk_mst`. The divider has run undisturbed since reset, so the counter wrap marks every frame start.

The stimulus drives all writes and flag changes on falling master edges. It releases reset on a falling edge. It never writes in the cycle of a counter wrap, so the pending-select behaviour is seen at one well-defined boundary. The oscillator and PLL clocks run free at unrelated periods and are sampled one time unit after their own edges.

// File: rtl/tbus_clkgen_pkg.sv
package tbus_clkgen_pkg;

  typedef enum logic [2:0] {
    FS_OFF    = 3'd0,
    FS_OSC    = 3'd1,
    FS_PLL    = 3'd2,
    FS_PLL_D2 = 3'd3,
    FS_R2M    = 3'd4,
    FS_R4M    = 3'd5,
    FS_R8M    = 3'd6,
    FS_R16M   = 3'd7
  } fsel_e;

  // Control byte, MSB first: select[7:5], rx mode[4], en A[3], en B[2], bus 8M[1], spare[0]
  typedef struct packed {
    fsel_e fsel;
    logic  rx_c8;
    logic  en_a;
    logic  en_b;
    logic  bus_c8;
    logic  spare;
  } ctl_t;

  // Level of the divided clock of the given stage (stage 0 = half master rate)
  function automatic logic rate_level(input logic [31:0] cnt, input int stage);
    return ~cnt[stage];
  endfunction

  // Frame pulse is asserted on the first two counts of a frame
  function automatic logic frame_low(input logic [31:0] cnt);
    return (cnt[31:1] == 31'd0);
  endfunction

endpackage

// File: rtl/tbus_cfg_reg.sv
module tbus_cfg_reg
  import tbus_clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctl_t       ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= ctl_t'(wdata);
  end

endmodule

// File: rtl/tbus_divider.sv
module tbus_divider
  import tbus_clkgen_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter int N_RATES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [N_RATES-1:0] rate_q,
  output logic               frm_n_q,
  output logic               wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign wrap   = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // Each rate is registered from the next count, so its edges carry no glitch
  for (genvar r = 0; r < N_RATES; r++) begin : g_rate
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rate_q[r] <= 1'b1;
      else        rate_q[r] <= rate_level(32'(cnt_nx), r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frm_n_q <= 1'b0;
    else        frm_n_q <= ~frame_low(32'(cnt_nx));
  end

endmodule

// File: rtl/tbus_fclk_mux.sv
module tbus_fclk_mux
  import tbus_clkgen_pkg::*;
(
  input  logic       rst_n,
  input  logic       mst_clk,
  input  logic       osc_clk,
  input  logic       pll_clk,
  input  logic [2:0] rate_lvl,   // [0]=8M, [1]=4M, [2]=2M
  input  fsel_e      sel,
  output logic       fclk,
  output logic       fclk_oe
);

  logic pll_half;

  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) pll_half <= 1'b0;
    else        pll_half <= ~pll_half;
  end

  always_comb begin
    case (sel)
      FS_OSC:    fclk = osc_clk;
      FS_PLL:    fclk = pll_clk;
      FS_PLL_D2: fclk = pll_half;
      FS_R2M:    fclk = rate_lvl[2];
      FS_R4M:    fclk = rate_lvl[1];
      FS_R8M:    fclk = rate_lvl[0];
      FS_R16M:   fclk = mst_clk;
      default:   fclk = 1'b0;
    endcase
  end

  assign fclk_oe = (sel != FS_OFF);

endmodule

// File: rtl/tbus_clkgen.sv
module tbus_clkgen
  import tbus_clkgen_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic       clk_mst,
  input  logic       rst_n,
  input  logic       osc_clk,
  input  logic       pll_clk,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       fail_a,
  input  logic       fail_b,
  output logic [7:0] cfg_rdata,
  output logic       rx_c8_mode,
  output logic       pair_a_clk,
  output logic       pair_a_frm_n,
  output logic       pair_a_oe,
  output logic       pair_b_clk,
  output logic       pair_b_frm_n,
  output logic       pair_b_oe,
  output logic       fclk_out,
  output logic       fclk_oe
);

  localparam int N_RATES = 3;
  localparam int N_PAIRS = 2;

  ctl_t               ctl_q;
  logic [N_RATES-1:0] rate_q;
  logic               frm_n_q;
  logic               frame_wrap;
  fsel_e              sel_act;
  logic               bus_c8;
  logic               bus_clk;
  logic [N_PAIRS-1:0] pair_en;
  logic [N_PAIRS-1:0] pair_fail;
  logic [N_PAIRS-1:0] pair_oe;

  tbus_cfg_reg u_cfg (
    .clk   (clk_mst),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .ctl_q (ctl_q)
  );

  tbus_divider #(.CNT_W(CNT_W), .N_RATES(N_RATES)) u_div (
    .clk     (clk_mst),
    .rst_n   (rst_n),
    .rate_q  (rate_q),
    .frm_n_q (frm_n_q),
    .wrap    (frame_wrap)
  );

  // The pending select is adopted only when a new frame starts
  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n)          sel_act <= FS_OFF;
    else if (frame_wrap) sel_act <= ctl_q.fsel;
  end

  tbus_fclk_mux u_fmux (
    .rst_n    (rst_n),
    .mst_clk  (clk_mst),
    .osc_clk  (osc_clk),
    .pll_clk  (pll_clk),
    .rate_lvl (rate_q),
    .sel      (sel_act),
    .fclk     (fclk_out),
    .fclk_oe  (fclk_oe)
  );

  assign bus_c8  = ctl_q.bus_c8;
  assign bus_clk = bus_c8 ? rate_q[0] : ~rate_q[1];

  assign pair_en   = {ctl_q.en_b, ctl_q.en_a};
  assign pair_fail = {fail_b, fail_a};

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign pair_oe[p] = pair_en[p] & ~pair_fail[p];
  end

  assign pair_a_clk   = bus_clk;
  assign pair_b_clk   = bus_clk;
  assign pair_a_frm_n = frm_n_q;
  assign pair_b_frm_n = frm_n_q;
  assign pair_a_oe    = pair_oe[0];
  assign pair_b_oe    = pair_oe[1];

  assign cfg_rdata  = ctl_q;
  assign rx_c8_mode = ctl_q.rx_c8;

endmodule

// File: rtl/tbus_clkgen_chk.sv
module tbus_clkgen_chk (
  input logic       clk_mst,
  input logic       rst_n,
  input logic       fail_a,
  input logic       fail_b,
  input logic       pair_a_oe,
  input logic       pair_b_oe,
  input logic       pair_a_clk,
  input logic       pair_a_frm_n,
  input logic       frame_wrap,
  input logic       bus_c8,
  input logic [2:0] sel_act,
  input logic       fclk_oe
);

  AST_FAIL_A_OFF: assert property (@(posedge clk_mst) disable iff (!rst_n)
    fail_a |-> !pair_a_oe);  // R4

  AST_FAIL_B_OFF: assert property (@(posedge clk_mst) disable iff (!rst_n)
    fail_b |-> !pair_b_oe);  // R4

  AST_FAST_TOGGLE: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (bus_c8 && $past(bus_c8)) |-> (pair_a_clk != $past(pair_a_clk)));  // R3

  AST_FRAME_LOW: assert property (@(posedge clk_mst) disable iff (!rst_n)
    frame_wrap |=> ##1 !pair_a_frm_n);  // R2

  AST_FRAME_END: assert property (@(posedge clk_mst) disable iff (!rst_n)
    frame_wrap |=> ##2 pair_a_frm_n);  // R2

  AST_SEL_HOLD: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !$past(frame_wrap) |-> $stable(sel_act));  // R8

  AST_OFF_NO_OE: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (sel_act == 3'd0) |-> !fclk_oe);  // R8

endmodule

bind tbus_clkgen tbus_clkgen_chk u_chk (
  .clk_mst      (clk_mst),
  .rst_n        (rst_n),
  .fail_a       (fail_a),
  .fail_b       (fail_b),
  .pair_a_oe    (pair_a_oe),
  .pair_b_oe    (pair_b_oe),
  .pair_a_clk   (pair_a_clk),
  .pair_a_frm_n (pair_a_frm_n),
  .frame_wrap   (frame_wrap),
  .bus_c8       (bus_c8),
  .sel_act      (sel_act),
  .fclk_oe      (fclk_oe)
);

// File: tb/tbus_clkgen_test.sv
module tbus_clkgen_test;

  logic       clk_mst = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_clk = 1'b0;
  logic       pll_clk = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       fail_a = 1'b0;
  logic       fail_b = 1'b0;
  logic [7:0] cfg_rdata;
  logic       rx_c8_mode;
  logic       pair_a_clk, pair_a_frm_n, pair_a_oe;
  logic       pair_b_clk, pair_b_frm_n, pair_b_oe;
  logic       fclk_out, fclk_oe;

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  bit done = 0;

  tbus_clkgen uut (
    .clk_mst(clk_mst), .rst_n(rst_n), .osc_clk(osc_clk), .pll_clk(pll_clk),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .fail_a(fail_a), .fail_b(fail_b),
    .cfg_rdata(cfg_rdata), .rx_c8_mode(rx_c8_mode),
    .pair_a_clk(pair_a_clk), .pair_a_frm_n(pair_a_frm_n), .pair_a_oe(pair_a_oe),
    .pair_b_clk(pair_b_clk), .pair_b_frm_n(pair_b_frm_n), .pair_b_oe(pair_b_oe),
    .fclk_out(fclk_out), .fclk_oe(fclk_oe)
  );

  always #5 clk_mst = ~clk_mst;
  always #7 osc_clk = ~osc_clk;
  always #3 pll_clk = ~pll_clk;

  // Master cycles since reset release
  always @(posedge clk_mst) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  // Expected level of a rate whose period is 2^(stage+1) master cycles
  function automatic bit e_rate(input int kk, input int stage);
    return (kk % (2 << stage)) < (1 << stage);
  endfunction

  function automatic bit e_frm(input int kk);
    return (kk % 2048) >= 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk_mst);
    cfg_we = 1'b1;
    cfg_wdata = b;
    @(negedge clk_mst);
    cfg_we = 1'b0;
  endtask

  task automatic wait_phase(input int p);
    do @(negedge clk_mst); while ((k % 2048) != p);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
    end
  end

  initial begin
    bit prev;
    repeat (4) @(negedge clk_mst);
    rst_n = 1'b1;

    // R10: reset state
    chk(cfg_rdata == 8'h00, "R10 rdata", cfg_rdata, 0);
    chk(!pair_a_oe && !pair_b_oe, "R10 pair oe", {pair_a_oe, pair_b_oe}, 0);
    chk(!fclk_oe, "R10 fclk_oe", fclk_oe, 0);
    chk(!rx_c8_mode, "R10 rx mode", rx_c8_mode, 0);

    // R8: select 100 is held pending until the wrap
    wr(8'h80);
    repeat (8) @(negedge clk_mst);
    chk(!fclk_oe, "R8 early", fclk_oe, 0);
    wait_phase(2047);
    chk(!fclk_oe, "R8 before wrap", fclk_oe, 0);
    @(negedge clk_mst);
    chk(fclk_oe, "R8 at wrap", fclk_oe, 1);
    for (int i = 0; i < 64; i++) begin
      chk(fclk_out == e_rate(k, 2), "R7 R1 2M", fclk_out, e_rate(k, 2));
      @(negedge clk_mst);
    end

    // R7 R1: 4M and 8M rates
    for (int code = 5; code <= 6; code++) begin
      wr(8'(code << 5));
      wait_phase(1);
      for (int i = 0; i < 64; i++) begin
        chk(fclk_out == e_rate(k, 6 - code), "R7 R1 rate", fclk_out, e_rate(k, 6 - code));
        @(negedge clk_mst);
      end
    end

    // R7: master clock passes through
    wr(8'hE0);
    wait_phase(1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_mst);
      chk(fclk_out == 1'b0, "R7 16M low", fclk_out, 0);
      @(posedge clk_mst); #2;
      chk(fclk_out == 1'b1, "R7 16M high", fclk_out, 1);
    end

    // R6: oscillator and PLL pass-through
    wr(8'h20);
    wait_phase(1);
    for (int i = 0; i < 16; i++) begin
      @(negedge osc_clk); #1;
      chk(fclk_out == osc_clk && osc_clk == 1'b0, "R6 osc low", fclk_out, 0);
      @(posedge osc_clk); #1;
      chk(fclk_out == osc_clk && osc_clk == 1'b1, "R6 osc high", fclk_out, 1);
    end
    wr(8'h40);
    wait_phase(1);
    for (int i = 0; i < 16; i++) begin
      @(negedge pll_clk); #1;
      chk(fclk_out == 1'b0, "R6 pll low", fclk_out, 0);
      @(posedge pll_clk); #1;
      chk(fclk_out == 1'b1, "R6 pll high", fclk_out, 1);
    end

    // R11: PLL divided by two toggles on every rising PLL edge
    wr(8'h60);
    wait_phase(1);
    chk(fclk_oe, "R11 oe", fclk_oe, 1);
    @(posedge pll_clk); #1;
    prev = fclk_out;
    for (int i = 0; i < 16; i++) begin
      @(posedge pll_clk); #1;
      chk(fclk_out == !prev, "R11 toggle", fclk_out, !prev);
      prev = fclk_out;
    end

    // R6: code 000 tristates the framer clock
    wr(8'h00);
    wait_phase(1);
    chk(!fclk_oe, "R6 off", fclk_oe, 0);

    // R3 R5: bus clock formats, shared by both pairs
    wr(8'h0E);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_mst);
      chk(pair_a_clk == e_rate(k, 0), "R3 8M", pair_a_clk, e_rate(k, 0));
      chk(pair_b_clk == pair_a_clk && pair_b_frm_n == pair_a_frm_n, "R5 pairs",
          {pair_b_clk, pair_b_frm_n}, {pair_a_clk, pair_a_frm_n});
    end
    wr(8'h0C);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_mst);
      chk(pair_a_clk == !e_rate(k, 1), "R3 inv 4M", pair_a_clk, !e_rate(k, 1));
    end

    // R2: frame pulse across a boundary
    wait_phase(2040);
    for (int i = 0; i < 2060; i++) begin
      chk(pair_a_frm_n == e_frm(k), "R2 frame", pair_a_frm_n, e_frm(k));
      chk(pair_b_frm_n == pair_a_frm_n, "R5 frame", pair_b_frm_n, pair_a_frm_n);
      @(negedge clk_mst);
    end

    // R4: enable and failure sweep
    for (int en = 0; en < 4; en++) begin
      for (int f = 0; f < 4; f++) begin
        wr(8'((en[1] << 3) | (en[0] << 2) | 2));
        fail_a = f[1];
        fail_b = f[0];
        @(negedge clk_mst);
        chk(pair_a_oe == (en[1] & !f[1]), "R4 A oe", pair_a_oe, en[1] & !f[1]);
        chk(pair_b_oe == (en[0] & !f[0]), "R4 B oe", pair_b_oe, en[0] & !f[0]);
      end
    end
    fail_a = 1'b0;
    fail_b = 1'b0;

    // R9: bit 4 exported, bit 0 stored, neither affects outputs
    wr(8'h19);
    chk(cfg_rdata == 8'h19, "R9 readback", cfg_rdata, 8'h19);
    chk(rx_c8_mode, "R9 rx mode", rx_c8_mode, 1);
    chk(pair_a_oe && !pair_b_oe && !fclk_oe, "R9 enables",
        {pair_a_oe, pair_b_oe, fclk_oe}, 3'b100);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_mst);
      chk(pair_a_clk == !e_rate(k, 1), "R9 clock", pair_a_clk, !e_rate(k, 1));
      chk(pair_a_frm_n == e_frm(k), "R9 frame", pair_a_frm_n, e_frm(k));
    end
    wr(8'h08);
    chk(cfg_rdata == 8'h08 && !rx_c8_mode, "R9 cleared", cfg_rdata, 8'h08);
    @(negedge clk_mst);
    chk(pair_a_clk == !e_rate(k, 1), "R9 clock after", pair_a_clk, !e_rate(k, 1));

    done = 1;
    summary();
  end

endmodule